// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block drains packets from two circular transmit descriptor rings kept in system memory. One ring is the high-priority queue and the other the low-priority queue. For each queue, the host programs a pointer register with the head descriptor of that queue's ring. The host then writes a command word that names one or both queues. The engine walks each named ring once, from the head pointer all the way round until a descriptor's next link points back at the head. Each descriptor the engine owns is sent as a single packet on a byte stream. The engine then hands the descriptor back to the host and raises a per-queue cause bit.

Memory is reached through a single-word request/ready master port, and every access finishes before the next one starts. Packet bytes leave one per cycle and carry start and end markers. An interrupt line is raised at the end of a queue sweep if any cause bit is enabled by the mask. The host clears cause bits by writing a word that is ANDed into the cause register.

Top module: `txring_dma`

## Requirements
- R1: A descriptor at byte address D is read as four words at D, D+4, D+8 and D+12: control word, length word, buffer address, next link. The byte count is bits 31:16 of the length word, and bits 15:0 of that word are ignored.
- R2: A descriptor whose control bit 31 is clear is not transmitted and is not written back, so its memory words stay unchanged.
- R3: A sweep starts at the queue's pointer register and follows each next link. It ends once the next link just read equals the pointer register. The pointer register itself is not modified by a sweep.
- R4: An owned descriptor with a count from 1 to 2047 emits exactly that many bytes from its word-aligned buffer, least significant byte of each word first. The first byte carries the start marker and the last byte carries the end marker, including when the count is not a multiple of four.
- R5: An owned descriptor with a count of 0, or of 2048 or more, emits no bytes but is still completed.
- R6: Completing an owned descriptor writes its control word back with bit 31 cleared. It also sets cause bit 3 for the low queue (queue 0) or cause bit 2 for the high queue (queue 1).
- R7: A write to register index 2 starts the high queue if bit 23 is set and the low queue if bit 22 is set. When both are set, the high queue is swept first. A start written while a sweep runs is held and served once that sweep ends.
- R8: At the end of each queue sweep, `irq` goes high if the cause register ANDed with the mask (index 4, bits 3:0) is non-zero. `irq` falls once that AND becomes zero. Writing index 3 ANDs the written value into the cause register.
- R9: Register index 0 holds the low-queue pointer and index 1 the high-queue pointer. Both can be read and written. Index 3 reads the cause bits and index 4 reads the mask.
- R10: `busy` is high from the cycle after an accepted start until the last write-back of the last pending sweep has completed.
- R11: Only one memory request is open at a time. Address, direction and write data stay unchanged until `mem_ready` is seen.
- R12: After reset, all registers read zero, and `busy`, `irq` and `pkt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| mem_req | output | 1 | Memory request open |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| pkt_valid | output | 1 | Byte present on `pkt_data` |
| pkt_data | output | 8 | Packet byte |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |
| busy | output | 1 | Sweep running or pending |
| irq | output | 1 | Interrupt request |
| cause | output | 4 | Cause bits to the interrupt controller |

## Verification
The bench uses the default parameters: 32-bit addresses and a 2048-byte length limit. With a 256-word memory model, a count of exactly 2048 sits right on the limit and needs no buffer behind it. Buffer lengths of 1, 4, 5, 6 and 8 cover a partial first word, an exact word, and a spill into a second word. The rings used have one, three and four descriptors, so self-linked rings and mixed ownership are both exercised.

// File: rtl/txring_pkg.sv
package txring_pkg;
    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 16;
    localparam int CMD_HI_BIT = 23;
    localparam int CMD_LO_BIT = 22;
    localparam int CAUSE_W    = 4;
    localparam int CAUSE_TOP  = 3;
    localparam int NQ         = 2;

    localparam logic [2:0] REG_PTR_LO = 3'd0;
    localparam logic [2:0] REG_PTR_HI = 3'd1;
    localparam logic [2:0] REG_CMD    = 3'd2;
    localparam logic [2:0] REG_CAUSE  = 3'd3;
    localparam logic [2:0] REG_MASK   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DESC, ST_DATA, ST_EMIT, ST_WB, ST_STEP
    } walk_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] buf_a;
        logic [WORD_W-1:0] nxt;
    } desc_t;

    function automatic logic [CAUSE_W-1:0] queue_cause(input int q);
        return CAUSE_W'(1) << (CAUSE_TOP - q);
    endfunction

    function automatic logic [2:0] beat_bytes(input logic [LEN_W-1:0] rem);
        return (rem >= LEN_W'(4)) ? 3'd4 : rem[2:0];
    endfunction
endpackage

// File: rtl/txring_regs.sv
module txring_regs
    import txring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [2:0]             reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic [NQ-1:0][AW-1:0]  ptr_o,
    input  logic [NQ-1:0]          take_i,
    output logic [NQ-1:0]          pend_o,
    input  logic [NQ-1:0]          cause_set_i,
    input  logic                   sweep_done_i,
    output logic [CAUSE_W-1:0]     cause_o,
    output logic                   irq_o
);
    logic [CAUSE_W-1:0] cause_q, cause_d, mask_q, mask_d;
    logic [NQ-1:0]      start_bits;
    logic               hit_d;

    assign start_bits = (reg_wr && reg_addr == REG_CMD)
                      ? {reg_wdata[CMD_HI_BIT], reg_wdata[CMD_LO_BIT]} : '0;

    always_comb begin
        cause_d = cause_q;
        if (reg_wr && reg_addr == REG_CAUSE) cause_d = cause_d & reg_wdata[CAUSE_W-1:0];
        for (int q = 0; q < NQ; q++)
            if (cause_set_i[q]) cause_d = cause_d | queue_cause(q);
        mask_d = (reg_wr && reg_addr == REG_MASK) ? reg_wdata[CAUSE_W-1:0] : mask_q;
        hit_d  = |(cause_d & mask_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o   <= '0;
            pend_o  <= '0;
            cause_q <= '0;
            mask_q  <= '0;
            irq_o   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == REG_PTR_LO) ptr_o[0] <= reg_wdata[AW-1:0];
            if (reg_wr && reg_addr == REG_PTR_HI) ptr_o[1] <= reg_wdata[AW-1:0];
            pend_o  <= (pend_o & ~take_i) | start_bits;
            cause_q <= cause_d;
            mask_q  <= mask_d;
            if (sweep_done_i && hit_d) irq_o <= 1'b1;
            else if (!hit_d)           irq_o <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_PTR_LO: reg_rdata = WORD_W'(ptr_o[0]);
            REG_PTR_HI: reg_rdata = WORD_W'(ptr_o[1]);
            REG_CAUSE:  reg_rdata = WORD_W'(cause_q);
            REG_MASK:   reg_rdata = WORD_W'(mask_q);
            default:    reg_rdata = '0;
        endcase
    end

    assign cause_o = cause_q;

    // R8: a raised line is always backed by an enabled cause bit
    p_irq_backed_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> |(cause_q & mask_q));
    // R6: completions only ever set bits, except through a host write
    p_cause_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && reg_addr == REG_CAUSE) |-> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/txring_emitter.sv
module txring_emitter
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [2:0]        nbytes_i,
    input  logic              sop_i,
    input  logic              eop_i,
    output logic              busy_o,
    output logic              pkt_valid,
    output logic [7:0]        pkt_data,
    output logic              pkt_sop,
    output logic              pkt_eop
);
    logic [WORD_W-1:0] sh;
    logic [2:0]        cnt;
    logic              sop_f, eop_f, beat0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0; cnt <= '0; sop_f <= 1'b0; eop_f <= 1'b0; beat0 <= 1'b0;
        end else if (load_i) begin
            sh <= word_i; cnt <= nbytes_i; sop_f <= sop_i; eop_f <= eop_i; beat0 <= 1'b1;
        end else if (cnt != 3'd0) begin
            sh    <= {8'h00, sh[WORD_W-1:8]};
            cnt   <= cnt - 3'd1;
            beat0 <= 1'b0;
        end
    end

    assign pkt_valid = (cnt != 3'd0);
    assign pkt_data  = sh[7:0];
    assign pkt_sop   = pkt_valid && sop_f && beat0;
    assign pkt_eop   = pkt_valid && eop_f && (cnt == 3'd1);
    assign busy_o    = pkt_valid;

    // R4: a new word is loaded only once the previous one has drained
    p_load_idle_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !busy_o);
    // R4: the byte after a packet's last byte opens a new packet
    p_sop_after_eop_r4: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && $past(pkt_valid && pkt_eop)) |-> pkt_sop);
endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txring_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_LEN = 2048
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NQ-1:0][AW-1:0] ptr_i,
    input  logic [NQ-1:0]         pend_i,
    output logic [NQ-1:0]         take_o,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic                  mem_ready,
    input  logic [WORD_W-1:0]     mem_rdata,
    output logic                  em_load,
    output logic [2:0]            em_nbytes,
    output logic                  em_sop,
    output logic                  em_eop,
    input  logic                  em_busy,
    output logic [NQ-1:0]         cause_set_o,
    output logic                  sweep_done_o,
    output logic                  active_o
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    walk_st_e         st;
    logic             q;
    logic [AW-1:0]    cur;
    logic [1:0]       idx;
    desc_t            d;
    logic [LEN_W-1:0] remaining;
    logic             first;

    always_comb begin
        take_o = '0;
        if (st == ST_IDLE) begin
            if (pend_i[1])      take_o = 2'b10;
            else if (pend_i[0]) take_o = 2'b01;
        end
    end

    assign mem_req   = (st == ST_DESC) || (st == ST_DATA) || (st == ST_WB);
    assign mem_we    = (st == ST_WB);
    assign mem_addr  = (st == ST_DATA) ? d.buf_a[AW-1:0]
                     : (st == ST_DESC) ? cur + AW'({idx, 2'b00}) : cur;
    assign mem_wdata = d.ctl & ~(WORD_W'(1) << OWN_BIT);

    assign em_load   = (st == ST_DATA) && mem_ready;
    assign em_nbytes = beat_bytes(remaining);
    assign em_sop    = first;
    assign em_eop    = (remaining <= LEN_W'(4));

    assign cause_set_o  = (st == ST_WB && mem_ready) ? {q, !q} : '0;
    assign sweep_done_o = (st == ST_STEP) && (d.nxt[AW-1:0] == ptr_i[q]);
    assign active_o     = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; q <= 1'b0; cur <= '0; idx <= '0;
            d <= '0; remaining <= '0; first <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (|pend_i) begin
                    q   <= pend_i[1];
                    cur <= pend_i[1] ? ptr_i[1] : ptr_i[0];
                    idx <= '0;
                    st  <= ST_DESC;
                end
                ST_DESC: if (mem_ready) begin
                    idx <= idx + 2'd1;
                    case (idx)
                        2'd0: d.ctl   <= mem_rdata;
                        2'd1: d.len   <= mem_rdata[LEN_LSB +: LEN_W];
                        2'd2: d.buf_a <= mem_rdata;
                        default: begin
                            d.nxt <= mem_rdata;
                            if (!d.ctl[OWN_BIT])
                                st <= ST_STEP;
                            else if (d.len == '0 || d.len >= LEN_LIMIT)
                                st <= ST_WB;
                            else begin
                                remaining <= d.len;
                                first     <= 1'b1;
                                st        <= ST_DATA;
                            end
                        end
                    endcase
                end
                ST_DATA: if (mem_ready) begin
                    remaining <= remaining - LEN_W'(em_nbytes);
                    d.buf_a   <= d.buf_a + WORD_W'(4);
                    first     <= 1'b0;
                    st        <= ST_EMIT;
                end
                ST_EMIT: if (!em_busy) st <= (remaining == '0) ? ST_WB : ST_DATA;
                ST_WB:   if (mem_ready) st <= ST_STEP;
                ST_STEP: begin
                    if (d.nxt[AW-1:0] == ptr_i[q]) st <= ST_IDLE;
                    else begin
                        cur <= d.nxt[AW-1:0];
                        idx <= '0;
                        st  <= ST_DESC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R11: an open request holds still until it is accepted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R6: a write-back always returns the descriptor to the host
    p_wb_release_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
    // R6: a completion touches one queue's cause bit at a time
    p_one_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause_set_o));
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MAX_LEN = 2048
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               pkt_valid,
    output logic [7:0]         pkt_data,
    output logic               pkt_sop,
    output logic               pkt_eop,
    output logic               busy,
    output logic               irq,
    output logic [CAUSE_W-1:0] cause
);
    logic [NQ-1:0][AW-1:0] ptr;
    logic [NQ-1:0]         pend, take, cause_set;
    logic                  sweep_done, active;
    logic                  em_load, em_sop, em_eop, em_busy;
    logic [2:0]            em_nbytes;

    txring_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr_o(ptr),
        .take_i(take), .pend_o(pend), .cause_set_i(cause_set),
        .sweep_done_i(sweep_done), .cause_o(cause), .irq_o(irq)
    );

    txring_walker #(.AW(AW), .MAX_LEN(MAX_LEN)) u_walker (
        .clk(clk), .rst(rst), .ptr_i(ptr), .pend_i(pend), .take_o(take),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .em_load(em_load), .em_nbytes(em_nbytes), .em_sop(em_sop),
        .em_eop(em_eop), .em_busy(em_busy), .cause_set_o(cause_set),
        .sweep_done_o(sweep_done), .active_o(active)
    );

    txring_emitter u_emit (
        .clk(clk), .rst(rst), .load_i(em_load), .word_i(mem_rdata),
        .nbytes_i(em_nbytes), .sop_i(em_sop), .eop_i(em_eop),
        .busy_o(em_busy), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_sop(pkt_sop), .pkt_eop(pkt_eop)
    );

    assign busy = active || (|pend);

    // R10: memory traffic and packet bytes only occur while busy
    p_busy_cover_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req || pkt_valid) |-> busy);
endmodule

// File: tb/txring_dma_test.sv
module txring_dma_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        pkt_valid, pkt_sop, pkt_eop, busy, irq;
    logic [7:0]  pkt_data;
    logic [3:0]  cause;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [256];
    logic [9:0]  exp_q [$];

    always #5 clk = ~clk;

    txring_dma uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
        .busy(busy), .irq(irq), .cause(cause)
    );

    // memory model: one-cycle acceptance delay
    always @(posedge clk) begin
        if (rst) mem_ready <= 1'b0;
        else begin
            if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            mem_ready <= mem_req && !mem_ready;
        end
    end
    assign mem_rdata = mem[mem_addr[9:2]];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: scoreboard of {sop, eop, byte}
    always @(negedge clk) begin
        if (!rst && pkt_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {22'h0, pkt_sop, pkt_eop, pkt_data}, 32'h0);
            else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({pkt_sop, pkt_eop, pkt_data} == e, "R4 byte/markers",
                    {22'h0, pkt_sop, pkt_eop, pkt_data}, {22'h0, e});
            end
        end
    end

    task automatic host_wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // driver: lay down a descriptor and push the bytes it must produce
    task automatic put_desc(input int da, input bit own, input int len, input int ba,
                            input int nxt, input logic [7:0] seed);
        mem[da/4]     = {own, 31'h0000_0155};
        mem[da/4 + 1] = {len[15:0], 16'hBEEF};
        mem[da/4 + 2] = ba;
        mem[da/4 + 3] = nxt;
        if (len > 0 && len < 64) begin
            for (int w = 0; w < (len + 3) / 4; w++)
                mem[ba/4 + w] = {seed + 8'(4*w+3), seed + 8'(4*w+2), seed + 8'(4*w+1), seed + 8'(4*w)};
        end
        if (own && len > 0 && len < 2048)
            for (int b = 0; b < len; b++)
                exp_q.push_back({b == 0, b == len - 1, seed + 8'(b)});
    endtask

    task automatic wait_idle;
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk(!busy && !irq && !pkt_valid, "R12 outputs after reset", {busy, irq, pkt_valid}, 0);
        host_rd(3'd0, v); chk(v == 0, "R12 pointer reset", v, 0);
        host_rd(3'd3, v); chk(v == 0, "R12 cause reset", v, 0);

        // R9 register access
        host_wr(3'd0, 32'h40); host_wr(3'd1, 32'h80); host_wr(3'd4, 32'hC);
        host_rd(3'd0, v); chk(v == 32'h40, "R9 low pointer", v, 32'h40);
        host_rd(3'd1, v); chk(v == 32'h80, "R9 high pointer", v, 32'h80);
        host_rd(3'd4, v); chk(v == 32'hC, "R9 mask", v, 32'hC);

        // R1 R2 R3 R4: three-entry low ring with an unowned middle descriptor
        put_desc(32'h40, 1, 5, 32'h200, 32'h50, 8'h10);
        put_desc(32'h50, 0, 3, 32'h220, 32'h60, 8'h30);
        put_desc(32'h60, 1, 8, 32'h240, 32'h40, 8'h50);
        host_wr(3'd2, 32'h1 << 22);
        chk(busy, "R10 busy after start", busy, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R3 R4 all low-ring bytes seen", exp_q.size(), 0);
        chk(mem[32'h40/4][31] == 0, "R6 first owned released", mem[32'h40/4], 32'h155);
        chk(mem[32'h60/4][31] == 0, "R6 third owned released", mem[32'h60/4], 32'h155);
        chk(mem[32'h50/4] == 32'h155, "R2 unowned untouched", mem[32'h50/4], 32'h155);
        host_rd(3'd3, v); chk(v == 32'h8, "R6 low cause bit 3", v, 32'h8);
        chk(irq, "R8 irq after low sweep", irq, 1);
        host_rd(3'd0, v); chk(v == 32'h40, "R3 pointer kept", v, 32'h40);

        // R8 cause clear by AND
        host_wr(3'd3, 32'h0);
        host_rd(3'd3, v); chk(v == 0, "R8 cause cleared", v, 0);
        chk(!irq, "R8 irq falls", irq, 0);

        // R5 R4: high ring with over-limit, empty, single and whole-word entries
        put_desc(32'h80, 1, 2048, 32'h260, 32'h90, 8'h00);
        put_desc(32'h90, 1, 0, 32'h260, 32'hA0, 8'h00);
        put_desc(32'hA0, 1, 1, 32'h280, 32'hB0, 8'h70);
        put_desc(32'hB0, 1, 4, 32'h2A0, 32'h80, 8'h90);
        host_wr(3'd2, 32'h1 << 23);
        wait_idle();
        chk(exp_q.size() == 0, "R4 R5 high-ring bytes", exp_q.size(), 0);
        chk(mem[32'h80/4][31] == 0, "R5 over-limit completed", mem[32'h80/4], 32'h155);
        chk(mem[32'h90/4][31] == 0, "R5 zero count completed", mem[32'h90/4], 32'h155);
        host_rd(3'd3, v); chk(v == 32'h4, "R6 high cause bit 2", v, 32'h4);

        // R7 both queues in one write: high first
        host_wr(3'd3, 32'h0);
        host_wr(3'd1, 32'hC0); host_wr(3'd0, 32'hD0);
        put_desc(32'hC0, 1, 6, 32'h2C0, 32'hC0, 8'hA0);
        put_desc(32'hD0, 1, 3, 32'h2E0, 32'hD0, 8'hC0);
        host_wr(3'd2, (32'h1 << 23) | (32'h1 << 22));
        wait_idle();
        chk(exp_q.size() == 0, "R7 high before low", exp_q.size(), 0);
        host_rd(3'd3, v); chk(v == 32'hC, "R7 both causes", v, 32'hC);

        // R7 start held while a sweep runs
        put_desc(32'hC0, 1, 6, 32'h2C0, 32'hC0, 8'hA0);
        put_desc(32'hD0, 1, 3, 32'h2E0, 32'hD0, 8'hC0);
        host_wr(3'd2, 32'h1 << 23);
        repeat (3) @(negedge clk);
        chk(busy, "R10 busy mid-sweep", busy, 1);
        host_wr(3'd2, 32'h1 << 22);
        wait_idle();
        chk(exp_q.size() == 0, "R7 latched start served", exp_q.size(), 0);
        chk(mem[32'hD0/4][31] == 0, "R7 latched low completed", mem[32'hD0/4], 32'h155);

        // R8 masked cause raises nothing
        host_wr(3'd3, 32'h0); host_wr(3'd4, 32'h0);
        put_desc(32'hD0, 1, 3, 32'h2E0, 32'hD0, 8'hC0);
        host_wr(3'd2, 32'h1 << 22);
        wait_idle();
        chk(!irq, "R8 masked irq low", irq, 0);
        chk(cause == 4'h8, "R8 cause still set", cause, 4'h8);
        chk(!busy, "R10 idle at end", busy, 0);

        summary();
        $finish;
    end
endmodule